// File: doc/BRIEF.md
# Frame-Synchronized Serial Port

This block is a full-duplex serial port for codecs, serial converters and links between processors. Its transmit and receive sections run separately. Each section has its own bit clock, its own frame-sync input and its own shift register, and all of these come from outside the block. A frame starts when the frame-sync input is high at a falling edge of that section's bit clock. After that, one bit moves per bit clock, most significant bit first. A frame is 8 bits or 16 bits long, chosen separately for each section.

Software uses two register locations on a simple select/write bus. A write to the transmit register holds the next word to send. The receive register holds the most recently completed incoming word. Each section raises a one-cycle interrupt pulse. The transmit pulse means the transmit register has been copied into the shift register and may be written again. The receive pulse means a new word is waiting.

The external bit clocks, frame syncs and receive data pass through synchronizers into the system clock domain. The bit clocks must therefore be several times slower than the system clock. The transmit data pin is released to high impedance outside a frame, so several ports can share one line. The `tx_drive` output reports when the block drives that pin.

Top module: `sync_serial_port`

## Requirements
- R1: After reset both registers read zero, both interrupt outputs are low and `tx_drive` is low.
- R2: A bus write with `bus_addr`=0 loads the transmit register, and a read at address 0 returns it. Address 1 reads the receive register. Writes to address 1 have no effect on it.
- R3: When a section's mode input is low (byte mode), only bits 7:0 of its register are kept, and bits 15:8 read as zero. When the mode input is high, all 16 bits are used.
- R4: When the transmit frame-sync is high at a falling edge of the transmit bit clock and no frame is in progress, or the current frame is on its last bit, a new frame starts. At that moment the transmit register is copied into the shift register and `tx_irq` pulses high for exactly one system clock.
- R5: During a transmit frame, `tx_dout` presents the copied word MSB first. It moves to the next bit on each later falling edge of the bit clock. The frame lasts 16 bits if `tx_wide` was high at frame start and 8 bits otherwise. A register write during a frame does not alter the bits being sent.
- R6: `tx_drive` is high only during a transmit frame. At the falling edge that follows the last bit, `tx_drive` goes low unless a new frame starts. `tx_dout` is high impedance whenever `tx_drive` is low.
- R7: When the receive frame-sync is high at a falling edge of the receive bit clock, the receiver arms. It then samples `rx_din` on each following rising edge, MSB first, for 16 bits if `rx_wide` was high when it armed and 8 bits otherwise.
- R8: After the last receive bit, the receive register takes the assembled word, zero-extended in byte mode, and `rx_irq` pulses for exactly one system clock. The register changes at no other time.
- R9: Transmit and receive operate at the same time on unrelated bit clocks without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 1 | 0 = transmit register, 1 = receive register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (zero when not selected) |
| tx_wide | input | 1 | Transmit mode: 1 = 16-bit, 0 = 8-bit |
| rx_wide | input | 1 | Receive mode: 1 = 16-bit, 0 = 8-bit |
| tx_bclk | input | 1 | External transmit bit clock |
| tx_fsync | input | 1 | Transmit frame-sync pulse |
| tx_dout | output | 1 | Serial transmit data, high impedance when idle |
| tx_drive | output | 1 | High while `tx_dout` is driven |
| rx_bclk | input | 1 | External receive bit clock |
| rx_fsync | input | 1 | Receive frame-sync pulse |
| rx_din | input | 1 | Serial receive data |
| tx_irq | output | 1 | One-cycle pulse at transmit frame start |
| rx_irq | output | 1 | One-cycle pulse when a received word is stored |

## Verification
A wrong transmit bit counter or mode latch shows up at the pins within one bit period. `tx_drive` then stays high past the eighth or sixteenth bit, or drops too early, and the sampled `tx_dout` sequence loses or repeats a bit. A receive shift register that is misaligned or not cleared leaves the wrong value in the receive register by the interrupt that ends the frame. The missing or doubled interrupt pulse appears in that same frame. A stale transmit copy, from loading at write time instead of at frame start, shows up in the frame after a write made mid-frame.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

   typedef enum logic {
      SSP_REG_TX = 1'b0,
      SSP_REG_RX = 1'b1
   } ssp_reg_e;

   function automatic logic [15:0] ssp_byte_mask16(input logic [15:0] v, input logic wide);
      return wide ? v : {8'h00, v[7:0]};
   endfunction

endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ssp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx #(
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk_fall,
   input  logic              fs_s,
   input  logic              wide,
   input  logic [WORD_W-1:0] load_word,
   output logic              bit_out,
   output logic              drive,
   output logic              irq
);
   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(WORD_W - 1);
   localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(BYTE_W - 1);

   logic [WORD_W-1:0] shreg;
   logic [CNT_W-1:0]  cnt;
   logic              active;
   logic              frm_wide;
   logic [CNT_W-1:0]  last;
   logic              on_last;
   logic              start;

   assign last    = frm_wide ? LAST_WORD : LAST_BYTE;
   assign on_last = active && (cnt == last);
   assign start   = bclk_fall && fs_s && (!active || on_last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg    <= '0;
         cnt      <= '0;
         active   <= 1'b0;
         frm_wide <= 1'b0;
         irq      <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (start) begin
            shreg    <= load_word;
            cnt      <= '0;
            active   <= 1'b1;
            frm_wide <= wide;
            irq      <= 1'b1;
         end else if (bclk_fall && active) begin
            if (on_last) begin
               active <= 1'b0;
            end else begin
               shreg <= shreg << 1;
               cnt   <= cnt + 1'b1;
            end
         end
      end
   end

   assign bit_out = frm_wide ? shreg[WORD_W-1] : shreg[BYTE_W-1];
   assign drive   = active;

   // R4: the interrupt marks the first bit of a freshly loaded frame
   p_irq_at_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (active && cnt == '0));

   // R5: the bit counter never runs past the frame length
   p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (cnt <= last));

   // R6: a completed frame with no new sync releases the line
   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (on_last && bclk_fall && !fs_s) |=> !drive);

   // R5: mid-frame the shift register only moves on a falling bit clock
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !bclk_fall) |=> $stable(shreg));
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk_rise,
   input  logic              bclk_fall,
   input  logic              fs_s,
   input  logic              din_s,
   input  logic              wide,
   output logic [WORD_W-1:0] word,
   output logic              irq
);
   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0]  LAST_WORD = CNT_W'(WORD_W - 1);
   localparam logic [CNT_W-1:0]  LAST_BYTE = CNT_W'(BYTE_W - 1);
   localparam logic [WORD_W-1:0] BYTE_MASK = {{(WORD_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

   logic [WORD_W-1:0] shreg;
   logic [WORD_W-1:0] shifted;
   logic [CNT_W-1:0]  cnt;
   logic              armed;
   logic              frm_wide;
   logic [CNT_W-1:0]  last;

   assign last    = frm_wide ? LAST_WORD : LAST_BYTE;
   assign shifted = {shreg[WORD_W-2:0], din_s};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg    <= '0;
         cnt      <= '0;
         armed    <= 1'b0;
         frm_wide <= 1'b0;
         word     <= '0;
         irq      <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (bclk_fall && fs_s && !armed) begin
            armed    <= 1'b1;
            cnt      <= '0;
            frm_wide <= wide;
            shreg    <= '0;
         end else if (bclk_rise && armed) begin
            shreg <= shifted;
            if (cnt == last) begin
               word  <= frm_wide ? shifted : (shifted & BYTE_MASK);
               irq   <= 1'b1;
               armed <= 1'b0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R8: a stored word always ends an armed frame
   p_irq_ends_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (!armed && $past(armed)));

   // R8: one pulse per word
   p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R8: a byte frame leaves the upper bits clear
   p_byte_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !frm_wide) |-> (word[WORD_W-1:BYTE_W] == '0));

   // R7: the receive counter stays inside the frame
   p_cnt_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (cnt <= last));
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
   parameter int WORD_W      = 16,
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_we,
   input  logic        bus_addr,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata,
   input  logic        tx_wide,
   input  logic        rx_wide,
   input  logic        tx_bclk,
   input  logic        tx_fsync,
   output logic        tx_dout,
   output logic        tx_drive,
   input  logic        rx_bclk,
   input  logic        rx_fsync,
   input  logic        rx_din,
   output logic        tx_irq,
   output logic        rx_irq
);
   import ssp_pkg::*;

   generate
      if (WORD_W != 16) begin : g_bad_word
         $error("sync_serial_port: WORD_W must be 16 to match the bus");
      end
      if (BYTE_W < 1 || BYTE_W >= WORD_W) begin : g_bad_byte
         $error("sync_serial_port: BYTE_W must be below WORD_W");
      end
   endgenerate

   localparam int N_SYNC = 5;
   localparam int I_TCK = 0;
   localparam int I_TFS = 1;
   localparam int I_RCK = 2;
   localparam int I_RFS = 3;
   localparam int I_RDI = 4;

   logic [N_SYNC-1:0] raw_in;
   logic [N_SYNC-1:0] syn;

   assign raw_in = {rx_din, rx_fsync, rx_bclk, tx_fsync, tx_bclk};

   genvar gi;
   generate
      for (gi = 0; gi < N_SYNC; gi++) begin : g_sync
         ssp_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_in[gi]),
            .q     (syn[gi])
         );
      end
   endgenerate

   // edge detection on the synchronized bit clocks
   logic tck_prev, rck_prev;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tck_prev <= 1'b0;
         rck_prev <= 1'b0;
      end else begin
         tck_prev <= syn[I_TCK];
         rck_prev <= syn[I_RCK];
      end
   end

   logic tck_fall, rck_fall, rck_rise;
   assign tck_fall = tck_prev && !syn[I_TCK];
   assign rck_fall = rck_prev && !syn[I_RCK];
   assign rck_rise = !rck_prev && syn[I_RCK];

   // transmit holding register
   ssp_reg_e    acc_reg;
   logic [15:0] tx_hold;
   logic [15:0] rx_word;
   logic        tx_bit;

   assign acc_reg = ssp_reg_e'(bus_addr);

   always_ff @(posedge clk) begin
      if (!rst_n) tx_hold <= '0;
      else if (bus_sel && bus_we && acc_reg == SSP_REG_TX)
         tx_hold <= ssp_byte_mask16(bus_wdata, tx_wide);
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         if (acc_reg == SSP_REG_TX) bus_rdata = ssp_byte_mask16(tx_hold, tx_wide);
         else                       bus_rdata = ssp_byte_mask16(rx_word, rx_wide);
      end
   end

   ssp_tx #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .bclk_fall (tck_fall),
      .fs_s      (syn[I_TFS]),
      .wide      (tx_wide),
      .load_word (ssp_byte_mask16(tx_hold, tx_wide)),
      .bit_out   (tx_bit),
      .drive     (tx_drive),
      .irq       (tx_irq)
   );

   ssp_rx #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .bclk_rise (rck_rise),
      .bclk_fall (rck_fall),
      .fs_s      (syn[I_RFS]),
      .din_s     (syn[I_RDI]),
      .wide      (rx_wide),
      .word      (rx_word),
      .irq       (rx_irq)
   );

   assign tx_dout = tx_drive ? tx_bit : 1'bz;

   // R2 / R8: the receive register only moves with its interrupt, never from a bus write
   p_rx_reg_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_irq |-> $stable(rx_word));

   // R2: a write to the transmit location lands in the holding register
   p_tx_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && !bus_addr && tx_wide) |=> (tx_hold == $past(bus_wdata)));

   // R3: in byte mode the stored transmit word carries no upper bits after a write
   p_tx_byte_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && !bus_addr && !tx_wide) |=> (tx_hold[15:8] == 8'h00));
endmodule

// File: tb/sync_serial_port_bench.sv
`timescale 1ns/1ps
module sync_serial_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        tx_wide = 1'b1, rx_wide = 1'b1;
   logic        tx_bclk = 1'b1, tx_fsync = 1'b0;
   logic        rx_bclk = 1'b1, rx_fsync = 1'b0, rx_din = 1'b0;
   wire         tx_dout;
   logic        tx_drive, tx_irq, rx_irq;

   int checks = 0;
   int fails = 0;
   int tx_irq_cnt = 0;
   int rx_irq_cnt = 0;
   bit done = 1'b0;

   localparam int TX_HP = 6;
   localparam int RX_HP = 7;

   always #2.5 clk = ~clk;

   sync_serial_port u_sync_serial_port (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_wide(tx_wide), .rx_wide(rx_wide),
      .tx_bclk(tx_bclk), .tx_fsync(tx_fsync), .tx_dout(tx_dout), .tx_drive(tx_drive),
      .rx_bclk(rx_bclk), .rx_fsync(rx_fsync), .rx_din(rx_din),
      .tx_irq(tx_irq), .rx_irq(rx_irq)
   );

   always @(posedge clk) begin
      if (tx_irq) tx_irq_cnt <= tx_irq_cnt + 1;
      if (rx_irq) rx_irq_cnt <= rx_irq_cnt + 1;
   end

   function automatic logic [15:0] masked(input logic [15:0] v, input logic wide);
      return wide ? v : {8'h00, v[7:0]};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic a, output logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   // sends one transmit frame; optionally writes a new word mid-frame (R5)
   task automatic tx_frame(input logic wide, input logic [15:0] exp_word,
                           input bit do_mid, input logic [15:0] mid_word);
      int n = wide ? 16 : 8;
      int irq0 = tx_irq_cnt;
      int bad = 0;
      logic [15:0] got = '0;
      tx_fsync = 1'b1;
      repeat (TX_HP) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         tx_bclk = 1'b0;
         if (i == 1) tx_fsync = 1'b0;
         repeat (TX_HP) @(negedge clk);
         got[n-1-i] = tx_dout;
         if (tx_drive !== 1'b1) bad++;
         if (tx_dout !== exp_word[n-1-i]) bad++;
         tx_bclk = 1'b1;
         if (do_mid && i == 3) begin
            bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 1'b0; bus_wdata = mid_word;
            @(negedge clk);
            bus_sel = 1'b0; bus_we = 1'b0;
            repeat (TX_HP - 1) @(negedge clk);
         end else begin
            repeat (TX_HP) @(negedge clk);
         end
      end
      chk(bad == 0, "R5 transmit bits", got, exp_word);
      chk(tx_irq_cnt == irq0 + 1, "R4 tx_irq one pulse", 16'(tx_irq_cnt - irq0), 16'd1);
      tx_bclk = 1'b0;
      repeat (TX_HP) @(negedge clk);
      chk(tx_drive == 1'b0, "R6 release after last bit", {15'd0, tx_drive}, 16'd0);
      tx_bclk = 1'b1;
      repeat (TX_HP) @(negedge clk);
   endtask

   task automatic rx_frame(input logic wide, input logic [15:0] word);
      int n = wide ? 16 : 8;
      int irq0 = rx_irq_cnt;
      logic [15:0] rd;
      rx_fsync = 1'b1;
      repeat (RX_HP) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         rx_bclk = 1'b0;
         if (i == 1) rx_fsync = 1'b0;
         rx_din = word[n-1-i];
         repeat (RX_HP) @(negedge clk);
         rx_bclk = 1'b1;
         repeat (RX_HP) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      chk(rx_irq_cnt == irq0 + 1, "R8 rx_irq one pulse", 16'(rx_irq_cnt - irq0), 16'd1);
      bus_read(1'b1, rd);
      chk(rd == masked(word, wide), "R7 R8 received word", rd, masked(word, wide));
   endtask

   initial begin
      logic [15:0] rd, d0, d1, rw;
      logic        w;
      process::self().srandom(32'h5EED_0042);
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(tx_drive == 1'b0 && tx_irq == 1'b0 && rx_irq == 1'b0, "R1 outputs at reset",
          {13'd0, tx_drive, tx_irq, rx_irq}, 16'd0);
      rst_n = 1'b1;
      bus_read(1'b0, rd); chk(rd == 16'h0000, "R1 tx register reset", rd, 16'h0000);
      bus_read(1'b1, rd); chk(rd == 16'h0000, "R1 rx register reset", rd, 16'h0000);

      // R2 / R3 register access
      tx_wide = 1'b1;
      bus_write(1'b0, 16'hABCD);
      bus_read(1'b0, rd); chk(rd == 16'hABCD, "R2 tx write/read", rd, 16'hABCD);
      tx_wide = 1'b0;
      bus_read(1'b0, rd); chk(rd == 16'h00CD, "R3 byte mode read mask", rd, 16'h00CD);
      bus_write(1'b0, 16'h5A3C);
      tx_wide = 1'b1;
      bus_read(1'b0, rd); chk(rd == 16'h003C, "R3 byte mode store", rd, 16'h003C);
      bus_write(1'b1, 16'h1234);
      bus_read(1'b1, rd); chk(rd == 16'h0000, "R2 rx write ignored", rd, 16'h0000);

      // directed frames: all ones word, byte with MSB set
      tx_wide = 1'b1; rx_wide = 1'b1;
      bus_write(1'b0, 16'hFFFF);
      fork
         tx_frame(1'b1, 16'hFFFF, 1'b0, 16'h0);
         rx_frame(1'b1, 16'h8001);
      join
      tx_wide = 1'b0; rx_wide = 1'b0;
      bus_write(1'b0, 16'h7F80);
      fork
         tx_frame(1'b0, 16'h0080, 1'b0, 16'h0);
         rx_frame(1'b0, 16'hFF81);
      join
      bus_write(1'b1, 16'hFFFF);
      bus_read(1'b1, rd); chk(rd == 16'h0081, "R2 rx write ignored after frame", rd, 16'h0081);

      // R9 random full-duplex frames with mid-frame writes (R5)
      d0 = 16'($urandom);
      w  = 1'b1;
      tx_wide = w;
      bus_write(1'b0, d0);
      for (int k = 0; k < 8; k++) begin
         d1 = 16'($urandom);
         rw = 16'($urandom);
         rx_wide = 1'($urandom);
         fork
            tx_frame(w, masked(d0, w), 1'b1, d1);
            rx_frame(rx_wide, rw);
         join
         bus_read(1'b0, rd);
         chk(rd == masked(d1, w), "R9 R5 mid-frame write kept", rd, masked(d1, w));
         d0 = masked(d1, w);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule